// File: doc/BRIEF.md
# Selectable Wait State Generator

This block stretches memory bus cycles so that slow memory has time to answer. While a memory read or write strobe is active, it holds its `bus_ready` output low for a chosen number of clock periods. Each low period adds one wait period to the bus sequencer. A plain bus cycle gives memory roughly three clock periods for an access, and the block adds nothing on top of that unless it is asked to.

The start of every bus cycle is marked by `addr_strobe`. While that input is high, an internal chain of flip-flops is cleared. Once a memory strobe is active, a one enters the chain on every clock. The static `wait_count` input chooses which stage of the chain is watched. `bus_ready` stays low until the watched stage holds a one. The bus sequencer samples `bus_ready` at the end of its second period, and samples it again in each inserted wait period. With `wait_count` = 1, which is the usual board setting, each memory cycle gets exactly one wait period. I/O cycles always pass without delay.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, with no strobe active, `bus_ready` is 1.
- R2: With `wait_count` = 0, `bus_ready` stays 1 through whole memory read and write cycles.
- R3: With `wait_count` = k > 0, once a memory strobe becomes active after an `addr_strobe` pulse, `bus_ready` is 0 for exactly the first k clock periods in which the strobe is active, and 1 afterwards. A memory strobe means `mem_access` = 1 with `rd_strobe_n` = 0 or `wr_strobe_n` = 0.
- R4: When `mem_access` = 0 (an I/O cycle), `bus_ready` stays 1 whatever the strobes and `wait_count` are.
- R5: A clock period with `addr_strobe` = 1 restarts the count, so the next memory strobe again sees the full k periods of `bus_ready` = 0.
- R6: `bus_ready` is 1 whenever neither strobe is active, including the periods between bus cycles.
- R7: A write strobe (`wr_strobe_n` = 0) gets the same number of wait periods as a read strobe.
- R8: The largest setting, `wait_count` = MAX_WAIT (7 by default), inserts MAX_WAIT wait periods.
- R9: After `bus_ready` has returned to 1 within a cycle, it stays 1 until the next `addr_strobe`, even if the strobe drops and comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_strobe | input | 1 | High for the address period that begins each bus cycle |
| mem_access | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_strobe_n | input | 1 | Read strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| wait_count | input | SEL_W (3) | Number of wait periods, 0 to MAX_WAIT |
| bus_ready | output | 1 | High when the access may complete |

## Verification
The bench builds the block with MAX_WAIT = 7, which is the default, so the 3-bit selector covers every tap from 0 to the last stage of the chain. With that depth the bench can sweep the zero setting, the usual one-wait setting, a middle setting and the deepest tap in a single run. It can also test restarting the count with `addr_strobe` and a strobe that drops and returns without `addr_strobe`. A counter-based model is compared with `bus_ready` on every clock.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // Bus control inputs sampled in one clock period
  typedef struct packed {
    logic start;   // address period of a new cycle
    logic mem;     // 1 = memory, 0 = I/O
    logic rd_n;
    logic wr_n;
  } wsg_bus_t;
endpackage

// File: rtl/wsg_reset_sync.sv
module wsg_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wsg_strobe_decode.sv
module wsg_strobe_decode
  import wsg_pkg::*;
(
  input  wsg_bus_t bus,
  output logic     mem_strb,
  output logic     chain_clr
);
  always_comb begin
    mem_strb  = bus.mem & (~bus.rd_n | ~bus.wr_n);
    chain_clr = bus.start;
  end
endmodule

// File: rtl/wsg_shift_chain.sv
module wsg_shift_chain #(
  parameter int DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [DEPTH-1:0] chain_q
);
  logic [DEPTH-1:0] chain_d;
  logic             chain_en;

  // next state
  always_comb begin
    chain_en = clr | adv;
    chain_d  = '0;
    if (!clr) begin
      chain_d[0] = 1'b1;
      for (int i = 1; i < DEPTH; i++) chain_d[i] = chain_q[i-1];
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end
endmodule

// File: rtl/wsg_tap_mux.sv
module wsg_tap_mux #(
  parameter int DEPTH = 7,
  parameter int SEL_W = 3
) (
  input  logic [DEPTH-1:0] chain_q,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_done
);
  localparam int NTAPS = DEPTH + 1;
  logic [NTAPS-1:0] taps;

  // tap 0 means no waiting; tap i reads stage i-1
  assign taps[0] = 1'b1;
  for (genvar g = 1; g < NTAPS; g++) begin : g_tap
    assign taps[g] = chain_q[g-1];
  end

  if ((2 ** SEL_W) > NTAPS) begin : g_guard
    always_comb tap_done = (int'(sel) >= NTAPS) ? 1'b1 : taps[sel];
  end else begin : g_full
    always_comb tap_done = taps[sel];
  end
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int MAX_WAIT = 7,
  localparam int SEL_W   = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strobe,
  input  logic             mem_access,
  input  logic             rd_strobe_n,
  input  logic             wr_strobe_n,
  input  logic [SEL_W-1:0] wait_count,
  output logic             bus_ready
);
  logic              rst_sync_n;
  logic              mem_strb;
  logic              chain_clr;
  logic              tap_done;
  logic [MAX_WAIT-1:0] chain_q;
  wsg_bus_t          bus;

  assign bus = '{start: addr_strobe, mem: mem_access,
                 rd_n: rd_strobe_n, wr_n: wr_strobe_n};

  wsg_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsg_strobe_decode u_dec (
    .bus       (bus),
    .mem_strb  (mem_strb),
    .chain_clr (chain_clr)
  );

  wsg_shift_chain #(.DEPTH(MAX_WAIT)) u_chain (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (chain_clr),
    .adv     (mem_strb),
    .chain_q (chain_q)
  );

  wsg_tap_mux #(.DEPTH(MAX_WAIT), .SEL_W(SEL_W)) u_tap (
    .chain_q  (chain_q),
    .sel      (wait_count),
    .tap_done (tap_done)
  );

  // hold the bus only while a memory strobe waits on its tap
  assign bus_ready = ~(mem_strb & ~tap_done);
endmodule

// File: rtl/wait_state_gen_chk.sv
module wait_state_gen_chk #(
  parameter int MAX_WAIT = 7,
  localparam int SEL_W   = $clog2(MAX_WAIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_strobe,
  input logic             mem_access,
  input logic             rd_strobe_n,
  input logic             wr_strobe_n,
  input logic [SEL_W-1:0] wait_count,
  input logic             bus_ready
);
  logic strb;
  assign strb = mem_access & (~rd_strobe_n | ~wr_strobe_n);

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_n && wr_strobe_n) |-> bus_ready); // R6

  AST_ZERO_SEL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_count == '0) |-> bus_ready); // R2

  AST_IO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_access |-> bus_ready); // R4

  AST_RESTART_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && $stable(wait_count)) |=> (!strb || addr_strobe || (wait_count == '0) || !bus_ready)); // R5

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && bus_ready && !addr_strobe) |=> (!strb || addr_strobe || bus_ready || !$stable(wait_count))); // R9
endmodule

bind wait_state_gen wait_state_gen_chk #(.MAX_WAIT(MAX_WAIT)) u_chk (.*);

// File: tb/tb_wait_state_gen.sv
module tb_wait_state_gen;
  localparam int MAX_WAIT = 7;
  localparam int SEL_W    = $clog2(MAX_WAIT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_strobe = 1'b0;
  logic mem_access = 1'b0;
  logic rd_strobe_n = 1'b1;
  logic wr_strobe_n = 1'b1;
  logic [SEL_W-1:0] wait_count = '0;
  logic bus_ready;

  int checks = 0;
  int errors = 0;
  int cnt = 0;  // model: strobe periods seen since last address period
  bit done = 0;

  always #5 clk = ~clk;

  wait_state_gen #(.MAX_WAIT(MAX_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
    .mem_access(mem_access), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .wait_count(wait_count),
    .bus_ready(bus_ready)
  );

  // one clock period: drive after falling edge, compare, then update model
  task automatic step(input logic a, input logic m, input logic r,
                      input logic w, input string tag);
    logic strb, exp;
    @(negedge clk);
    addr_strobe = a; mem_access = m; rd_strobe_n = r; wr_strobe_n = w;
    #2;
    strb = m && (!r || !w);
    exp  = !(strb && (wait_count != 0) && (cnt < int'(wait_count)));
    checks++;
    if (bus_ready !== exp) begin
      errors++;
      $display("FAIL %s t=%0t bus_ready=%b expected=%b", tag, $time, bus_ready, exp);
    end
    @(posedge clk);
    if (a) cnt = 0;
    else if (strb && cnt < MAX_WAIT) cnt++;
  endtask

  // address period, strobe for len periods, one idle period
  task automatic bus_cycle(input logic m, input logic wr, input int len,
                           input string tag);
    step(1, m, 1, 1, "R6");
    for (int i = 0; i < len; i++) step(0, m, wr, !wr, tag);
    step(0, m, 1, 1, "R6");
  endtask

  initial begin
    wait_count = 3'd1;
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, "R1");

    wait_count = 3'd0;
    bus_cycle(1, 0, 5, "R2");
    bus_cycle(1, 1, 5, "R2");

    wait_count = 3'd1;
    bus_cycle(1, 0, 4, "R3");
    wait_count = 3'd3;
    bus_cycle(1, 0, 6, "R3");
    bus_cycle(1, 1, 6, "R7");

    wait_count = 3'd7;
    bus_cycle(1, 0, 10, "R8");
    bus_cycle(1, 1, 9, "R8");

    wait_count = 3'd5;
    bus_cycle(0, 0, 7, "R4");
    bus_cycle(0, 1, 7, "R4");

    // short strobe then restart by address period
    wait_count = 3'd4;
    step(1, 1, 1, 1, "R6");
    step(0, 1, 0, 1, "R5");
    step(0, 1, 0, 1, "R5");
    bus_cycle(1, 0, 6, "R5");

    // ready back high, strobe drops and returns without address period
    wait_count = 3'd2;
    step(1, 1, 1, 1, "R6");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R9");
    step(0, 1, 1, 1, "R6");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, "R9");
    step(0, 1, 1, 1, "R6");

    // strobe drops before count finishes, resumes where it left off
    wait_count = 3'd3;
    step(1, 1, 1, 1, "R6");
    step(0, 1, 0, 1, "R3");
    step(0, 1, 1, 1, "R6");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, "R3");
    step(0, 1, 1, 1, "R6");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule